// File: doc/BRIEF.md
# Sequence-End Field-Loss Checker

This controller sits beside a load modulator in a passive tag. The tag's own modulation keeps the field detector charged, so while modulation runs, the detector cannot see the reader field go away. When the modulator signals the end of a sequence, the controller turns modulation off. It then waits a parameterised settle time, long enough for the detector to drain, and only after that reads the field-present level. That level first passes through a two-flop synchronizer.

If the field has gone, the controller issues a one-cycle stop request to the modulator, followed one cycle later by a one-cycle field-lost pulse. Modulation stays off after a field loss until a later check finds the field present again. If the field is present, modulation is switched back on and a one-cycle continue pulse lets the next sequence start. The settle time is counted in clock cycles. The default is 2,000 cycles, which is 2 ms at 1 MHz.

Top module: `seqend_field_check`

## Requirements
- R1: After reset, `mod_en_o` is 1 and `stop_req_o`, `field_lost_o` and `cont_o` are all 0.
- R2: When `seq_end_i` is high at a clock edge while no check is running, `mod_en_o` is 0 after that same edge.
- R3: `mod_en_o` stays 0 for the whole check. The decision outputs appear exactly SETTLE_CYCLES+2 edges after the edge that accepted `seq_end_i`.
- R4: The level of `field_i` during the settle time has no effect. Only the synchronized level at the decision edge counts, and the input must be stable for at least three cycles before that edge.
- R5: A field level of 0 at the decision edge produces a single one-cycle `stop_req_o` pulse, and `mod_en_o` stays 0.
- R6: `field_lost_o` is a one-cycle pulse in the cycle right after `stop_req_o`, and it occurs only after a stop request.
- R7: A field level of 1 at the decision edge sets `mod_en_o` to 1 and gives a one-cycle `cont_o` pulse at the same edge.
- R8: `seq_end_i` pulses that arrive while a check is running are ignored. They start no second check and do not move the decision time.
- R9: After a field loss, `mod_en_o` stays 0 while idle. A later `seq_end_i` starts a new check, and `mod_en_o` rises again only together with a `cont_o` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| seq_end_i | input | 1 | End-of-sequence pulse from the modulator |
| field_i | input | 1 | Asynchronous field-present level from the detector |
| mod_en_o | output | 1 | Modulation drive enable |
| stop_req_o | output | 1 | One-cycle request to stop the modulator |
| field_lost_o | output | 1 | One-cycle field-loss indication |
| cont_o | output | 1 | One-cycle pulse: modulation restored, next sequence may start |

## Verification
The assertions assume that `seq_end_i` is a clean synchronous pulse. They also assume that `field_i` settles at least three cycles before the decision edge, so that the synchronizer output matches the level the bench intends. The stimulus changes the field level only on falling clock edges, and always well inside the settle window. It raises the sequence-end input only for single cycles, both from idle and in the middle of a running check.

// File: rtl/seqchk_pkg.sv
package seqchk_pkg;
  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_BLANK  = 3'd1,
    ST_SETTLE = 3'd2,
    ST_SAMPLE = 3'd3,
    ST_STOP   = 3'd4,
    ST_RESUME = 3'd5
  } chk_state_t;
endpackage

// File: rtl/field_sync.sv
module field_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] pipe;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) pipe <= '0;
        else     pipe <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) pipe <= '0;
        else     pipe <= {pipe[STAGES-2:0], din};
      end
    end
  endgenerate

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/settle_timer.sv
module settle_timer #(
  parameter int CYCLES = 2000
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic done
);
  localparam int CW = (CYCLES < 2) ? 1 : $clog2(CYCLES);
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt;
  logic          run;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      run <= 1'b0;
    end else if (start) begin
      cnt <= '0;
      run <= 1'b1;
    end else if (run) begin
      if (cnt == LAST) run <= 1'b0;
      else             cnt <= cnt + 1'b1;
    end
  end

  assign done = run && (cnt == LAST);

  p_done_needs_run_r3: assert property (@(posedge clk) disable iff (rst)
    done |=> !run);
endmodule

// File: rtl/check_fsm.sv
module check_fsm
  import seqchk_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic seq_end_i,
  input  logic field_ok_i,
  input  logic settle_done_i,
  output logic timer_start_o,
  output logic mod_en_o,
  output logic stop_req_o,
  output logic field_lost_o,
  output logic cont_o
);
  chk_state_t state;

  assign timer_start_o = (state == ST_BLANK);

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      mod_en_o     <= 1'b1;
      stop_req_o   <= 1'b0;
      field_lost_o <= 1'b0;
      cont_o       <= 1'b0;
    end else begin
      stop_req_o   <= 1'b0;
      field_lost_o <= 1'b0;
      cont_o       <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (seq_end_i) begin
            state    <= ST_BLANK;
            mod_en_o <= 1'b0;
          end
        end
        ST_BLANK:  state <= ST_SETTLE;
        ST_SETTLE: if (settle_done_i) state <= ST_SAMPLE;
        ST_SAMPLE: begin
          if (field_ok_i) begin
            state    <= ST_RESUME;
            mod_en_o <= 1'b1;
            cont_o   <= 1'b1;
          end else begin
            state      <= ST_STOP;
            stop_req_o <= 1'b1;
          end
        end
        ST_STOP: begin
          state        <= ST_IDLE;
          field_lost_o <= 1'b1;
        end
        ST_RESUME: state <= ST_IDLE;
        default:   state <= ST_IDLE;
      endcase
    end
  end

  p_blank_first_r2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && seq_end_i) |=> (!mod_en_o && state == ST_BLANK));
  p_off_during_check_r3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_BLANK || state == ST_SETTLE || state == ST_SAMPLE) |-> !mod_en_o);
  p_sample_after_settle_r4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SAMPLE) |-> $past(settle_done_i));
  p_stop_keeps_off_r5: assert property (@(posedge clk) disable iff (rst)
    stop_req_o |-> !mod_en_o);
  p_lost_after_stop_r6: assert property (@(posedge clk) disable iff (rst)
    field_lost_o |-> $past(stop_req_o));
  p_cont_with_mod_r7: assert property (@(posedge clk) disable iff (rst)
    cont_o |-> mod_en_o);
  p_settle_not_restarted_r8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SETTLE) |=> (state == ST_SETTLE || state == ST_SAMPLE));
  p_rise_via_cont_r9: assert property (@(posedge clk) disable iff (rst)
    $rose(mod_en_o) |-> cont_o);
  p_pulses_exclusive_r6: assert property (@(posedge clk) disable iff (rst)
    $onehot0({stop_req_o, field_lost_o, cont_o}));
endmodule

// File: rtl/seqend_field_check.sv
module seqend_field_check #(
  parameter int SETTLE_CYCLES = 2000,
  parameter int SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic seq_end_i,
  input  logic field_i,
  output logic mod_en_o,
  output logic stop_req_o,
  output logic field_lost_o,
  output logic cont_o
);
  logic field_ok;
  logic tmr_start;
  logic tmr_done;

  field_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  (field_i),
    .dout (field_ok)
  );

  settle_timer #(.CYCLES(SETTLE_CYCLES)) u_timer (
    .clk   (clk),
    .rst   (rst),
    .start (tmr_start),
    .done  (tmr_done)
  );

  check_fsm u_fsm (
    .clk           (clk),
    .rst           (rst),
    .seq_end_i     (seq_end_i),
    .field_ok_i    (field_ok),
    .settle_done_i (tmr_done),
    .timer_start_o (tmr_start),
    .mod_en_o      (mod_en_o),
    .stop_req_o    (stop_req_o),
    .field_lost_o  (field_lost_o),
    .cont_o        (cont_o)
  );
endmodule

// File: tb/seqend_field_check_test.sv
module seqend_field_check_test;
  localparam int N = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic seq_end = 1'b0;
  logic field = 1'b0;
  logic mod_en, stop_req, field_lost, cont;

  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;

  typedef struct { int kind; int at; } exp_t;
  exp_t expq[$];

  seqend_field_check #(.SETTLE_CYCLES(N)) uut (
    .clk (clk), .rst (rst), .seq_end_i (seq_end), .field_i (field),
    .mod_en_o (mod_en), .stop_req_o (stop_req),
    .field_lost_o (field_lost), .cont_o (cont)
  );

  always #10 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // monitor: kind 0 = stop request, 1 = field lost, 2 = continue
  task automatic observe(input int kind);
    if (expq.size() == 0) begin
      chk("R8 unexpected event", kind, -1);
    end else begin
      exp_t e = expq.pop_front();
      chk("R3/R5/R6/R7 event kind", kind, e.kind);
      chk("R3/R6 event cycle", cyc, e.at);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (stop_req)   observe(0);
      if (field_lost) observe(1);
      if (cont)       observe(2);
    end
  end

  task automatic run_check(input bit f0, input bit f1, input bit extra);
    int c0;
    field = f0;
    repeat (4) @(negedge clk);
    seq_end = 1'b1;
    @(negedge clk);
    seq_end = 1'b0;
    c0 = cyc;
    chk("R2 modulation off after sequence end", int'(mod_en), 0);
    if (f1) expq.push_back('{2, c0 + N + 2});
    else begin
      expq.push_back('{0, c0 + N + 2});
      expq.push_back('{1, c0 + N + 3});
    end
    repeat (3) @(negedge clk);
    field = f1;
    if (extra) begin
      seq_end = 1'b1; @(negedge clk); seq_end = 1'b0;
      repeat (3) @(negedge clk);
      seq_end = 1'b1; @(negedge clk); seq_end = 1'b0;
    end
    while (cyc < c0 + N) @(negedge clk);
    chk("R3 modulation still off during settle", int'(mod_en), 0);
    while (cyc < c0 + N + 8) @(negedge clk);
    chk(f1 ? "R7 modulation restored" : "R5 modulation kept off", int'(mod_en), int'(f1));
    chk("R3 scoreboard drained", expq.size(), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 mod_en reset", int'(mod_en), 1);
    chk("R1 stop_req reset", int'(stop_req), 0);
    chk("R1 field_lost reset", int'(field_lost), 0);
    chk("R1 cont reset", int'(cont), 0);
    rst = 1'b0;
    @(negedge clk);

    run_check(1'b1, 1'b1, 1'b0);   // R7 field present throughout
    run_check(1'b1, 1'b0, 1'b0);   // R4 R5 R6 field drops during settle
    repeat (20) @(negedge clk);
    chk("R9 modulation stays off while idle after loss", int'(mod_en), 0);
    run_check(1'b0, 1'b1, 1'b0);   // R4 R9 field returns during settle
    run_check(1'b1, 1'b1, 1'b1);   // R8 extra pulses ignored
    repeat (N + 10) @(negedge clk);
    chk("R8 no second check started", int'(mod_en), 1);
    run_check(1'b0, 1'b0, 1'b1);   // R5 R8 absent field, extra pulses
    repeat (10) @(negedge clk);
    chk("R9 off after second loss", int'(mod_en), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule